// File: doc/BRIEF.md
# Staged Pipeline Control Decoder

This block sits in the register-fetch/decode stage of a five-stage in-order pipeline. It turns the opcode and function fields of the instruction in decode into a full control bundle in one step. It then hands that bundle down through the EX, MEM and WB pipeline registers. Each register keeps only the controls that its own stage and the later stages still need. The EX register holds everything. The MEM register drops the EX controls. The WB register holds only the write-back pair and the destination index.

Loads, stores, branches and R-type instructions are decoded. Every class that writes the register file does so in stage five. R-type results therefore pass through MEM with no memory action, and two instructions never write the file in the same cycle. A bubble request puts an all-zero bundle in place of the decoded one. A three-bit flush mask clears chosen stage registers on the next edge. The ALU, the memories and the register file are outside the block. It only drives their controls.

Top module: `staged_ctrl_decoder`

## Requirements
- R1: While synchronous reset is high, every output after a clock edge is zero.
- R2: Opcode 6'h23 (load) gives, one edge later, extSign=1, aluImm=1, aluFn=0 (add) and pickRd=0. Two edges later it gives memWrite=0 and memBranch=0. Three edges later it gives wbMemToReg=1 and wbRegWrite=1.
- R3: Opcode 6'h00 (R-type) maps funct 6'h20/6'h22/6'h24/6'h25/6'h2A to aluFn 0 (add), 1 (sub), 2 (and), 3 (or) and 4 (slt). It also gives extSign=0, aluImm=0 and pickRd=1. The MEM group is idle, and the WB group is memToReg=0 with regWrite=1, three edges after decode.
- R4: Opcode 6'h2B (store) gives extSign=1, aluImm=1 and aluFn=add. memWrite=1 appears two edges after decode, and wbRegWrite stays 0.
- R5: Opcode 6'h04 (branch) gives extSign=1, aluImm=0 and aluFn=1 (sub). memBranch=1 appears two edges after decode, and wbRegWrite stays 0.
- R6: An instruction decoded at edge n shows its EX group after edge n, its MEM group after edge n+1 and its WB group after edge n+2. Back-to-back instructions of mixed classes do not disturb each other.
- R7: Any other opcode, and an R-type with any other funct, produces the all-zero bundle and index.
- R8: With bubbleReq high at an edge, the EX register loads the all-zero bundle, and that empty slot flows on to MEM and WB.
- R9: flushMask bit 0 clears the EX register, bit 1 clears MEM and bit 2 clears WB, each at the next edge. Stages whose bit is clear advance normally.
- R10: wbDest is the rd field for R-type and the rt field for load, store and branch. It is 0 for any bubbled, flushed or invalid slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction in decode |
| funct | input | 6 | Function field of the instruction in decode |
| srcRt | input | IDX_W | rt register field |
| srcRd | input | IDX_W | rd register field |
| bubbleReq | input | 1 | Insert an empty bundle instead of the decoded one |
| flushMask | input | 3 | Per-stage clear: bit0 EX, bit1 MEM, bit2 WB |
| exExtSign | output | 1 | EX: sign-extend the immediate |
| exAluImm | output | 1 | EX: ALU second operand is the immediate |
| exAluFn | output | 3 | EX: ALU function code |
| exPickRd | output | 1 | EX: destination is rd (1) or rt (0) |
| memWrite | output | 1 | MEM: data memory write |
| memBranch | output | 1 | MEM: instruction is a branch |
| wbMemToReg | output | 1 | WB: write-back data comes from memory |
| wbRegWrite | output | 1 | WB: register file write enable |
| wbDest | output | IDX_W | WB: destination register index |

## Verification
The bench drives a mixed instruction stream against a queue model and aims at the hand-over between stages. If the MEM register took its controls from the wrong source, or missed a cycle, a store's write strobe would land a cycle early or late, or beside a neighbouring instruction. Flush and bubble are applied on one stage at a time and in combinations. A design that clears the wrong stage, or lets a bubble keep a stale regWrite, would raise a spurious write-back. Invalid opcodes and unknown funct codes are mixed in. This catches a decoder that falls through to an R-type write. R-type and load share the write stage, so an R-type that wrote in stage four would show up as a WB group one cycle early.

// File: rtl/ctrl_pkg.sv
package ctrl_pkg;
  localparam int OP_W = 6;
  localparam int FN_W = 6;
  localparam int NSTG = 3;

  localparam logic [OP_W-1:0] OPC_RTYPE  = 6'h00;
  localparam logic [OP_W-1:0] OPC_LOAD   = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE  = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BRANCH = 6'h04;

  localparam logic [FN_W-1:0] FUN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FUN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FUN_AND = 6'h24;
  localparam logic [FN_W-1:0] FUN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FUN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } aluFn_e;

  typedef struct packed {
    logic   extSign;
    logic   aluImm;
    aluFn_e aluFn;
    logic   pickRd;
  } exCtl_t;

  typedef struct packed {
    logic memWrite;
    logic isBranch;
  } memCtl_t;

  typedef struct packed {
    logic memToReg;
    logic regWrite;
  } wbCtl_t;

  typedef struct packed {
    exCtl_t  ex;
    memCtl_t mem;
    wbCtl_t  wb;
  } fullCtl_t;

  typedef struct packed {
    memCtl_t mem;
    wbCtl_t  wb;
  } tailCtl_t;

  // strobes handed from control to the index datapath
  typedef struct packed {
    logic clrEx;
    logic clrMem;
    logic clrWb;
    logic pickRd;
  } stageStrobe_t;
endpackage

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import ctrl_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output fullCtl_t        decCtl,
  output logic            decValid
);
  fullCtl_t raw;
  logic     known;
  aluFn_e   rFn;
  logic     rKnown;

  always_comb begin
    rKnown = 1'b1;
    case (funct)
      FUN_ADD: rFn = ALU_ADD;
      FUN_SUB: rFn = ALU_SUB;
      FUN_AND: rFn = ALU_AND;
      FUN_OR:  rFn = ALU_OR;
      FUN_SLT: rFn = ALU_SLT;
      default: begin
        rFn    = ALU_ADD;
        rKnown = 1'b0;
      end
    endcase
  end

  always_comb begin
    raw   = '0;
    known = 1'b1;
    case (opcode)
      OPC_RTYPE: begin
        raw.ex.aluFn    = rFn;
        raw.ex.pickRd   = 1'b1;
        raw.wb.regWrite = 1'b1;
        known           = rKnown;
      end
      OPC_LOAD: begin
        raw.ex.extSign  = 1'b1;
        raw.ex.aluImm   = 1'b1;
        raw.ex.aluFn    = ALU_ADD;
        raw.wb.memToReg = 1'b1;
        raw.wb.regWrite = 1'b1;
      end
      OPC_STORE: begin
        raw.ex.extSign   = 1'b1;
        raw.ex.aluImm    = 1'b1;
        raw.ex.aluFn     = ALU_ADD;
        raw.mem.memWrite = 1'b1;
      end
      OPC_BRANCH: begin
        raw.ex.extSign   = 1'b1;
        raw.ex.aluFn     = ALU_SUB;
        raw.mem.isBranch = 1'b1;
      end
      default: known = 1'b0;
    endcase
  end

  assign decValid = known;
  assign decCtl   = known ? raw : '0;
endmodule

// File: rtl/ctrl_unit.sv
module ctrl_unit
  import ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  input  logic            bubbleReq,
  input  logic [NSTG-1:0] flushMask,
  output exCtl_t          exOut,
  output memCtl_t         memOut,
  output wbCtl_t          wbOut,
  output stageStrobe_t    strobe
);
  fullCtl_t decCtl;
  logic     decValid;
  fullCtl_t exReg;
  tailCtl_t memReg;
  wbCtl_t   wbReg;
  logic [NSTG-1:0] clrVec;

  ctrl_decode u_dec (
    .opcode  (opcode),
    .funct   (funct),
    .decCtl  (decCtl),
    .decValid(decValid)
  );

  // stage 0 also clears on a bubble or an undecodable instruction
  genvar s;
  generate
    for (s = 0; s < NSTG; s++) begin : g_clr
      if (s == 0) begin : g_head
        assign clrVec[s] = flushMask[s] | bubbleReq | ~decValid;
      end else begin : g_tail
        assign clrVec[s] = flushMask[s];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || clrVec[0]) exReg <= '0;
    else                  exReg <= decCtl;
  end

  always_ff @(posedge clk) begin
    if (rst || clrVec[1]) memReg <= '0;
    else                  memReg <= '{mem: exReg.mem, wb: exReg.wb};
  end

  always_ff @(posedge clk) begin
    if (rst || clrVec[2]) wbReg <= '0;
    else                  wbReg <= memReg.wb;
  end

  assign exOut  = exReg.ex;
  assign memOut = memReg.mem;
  assign wbOut  = wbReg;

  assign strobe.clrEx  = clrVec[0];
  assign strobe.clrMem = clrVec[1];
  assign strobe.clrWb  = clrVec[2];
  assign strobe.pickRd = exReg.ex.pickRd;
endmodule

// File: rtl/idx_path.sv
module idx_path
  import ctrl_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] srcRt,
  input  logic [IDX_W-1:0] srcRd,
  input  stageStrobe_t     strobe,
  output logic [IDX_W-1:0] wbIdx
);
  logic [IDX_W-1:0] exRt;
  logic [IDX_W-1:0] exRd;
  logic [IDX_W-1:0] memIdx;
  logic [IDX_W-1:0] wbIdxQ;

  always_ff @(posedge clk) begin
    if (rst || strobe.clrEx) begin
      exRt <= '0;
      exRd <= '0;
    end else begin
      exRt <= srcRt;
      exRd <= srcRd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clrMem) memIdx <= '0;
    else                      memIdx <= strobe.pickRd ? exRd : exRt;
  end

  always_ff @(posedge clk) begin
    if (rst || strobe.clrWb) wbIdxQ <= '0;
    else                     wbIdxQ <= memIdx;
  end

  assign wbIdx = wbIdxQ;
endmodule

// File: rtl/staged_ctrl_decoder.sv
module staged_ctrl_decoder
  import ctrl_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [5:0]       opcode,
  input  logic [5:0]       funct,
  input  logic [IDX_W-1:0] srcRt,
  input  logic [IDX_W-1:0] srcRd,
  input  logic             bubbleReq,
  input  logic [2:0]       flushMask,
  output logic             exExtSign,
  output logic             exAluImm,
  output logic [2:0]       exAluFn,
  output logic             exPickRd,
  output logic             memWrite,
  output logic             memBranch,
  output logic             wbMemToReg,
  output logic             wbRegWrite,
  output logic [IDX_W-1:0] wbDest
);
  exCtl_t       exOut;
  memCtl_t      memOut;
  wbCtl_t       wbOut;
  stageStrobe_t strobe;

  ctrl_unit u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .opcode   (opcode),
    .funct    (funct),
    .bubbleReq(bubbleReq),
    .flushMask(flushMask),
    .exOut    (exOut),
    .memOut   (memOut),
    .wbOut    (wbOut),
    .strobe   (strobe)
  );

  idx_path #(.IDX_W(IDX_W)) u_idx (
    .clk   (clk),
    .rst   (rst),
    .srcRt (srcRt),
    .srcRd (srcRd),
    .strobe(strobe),
    .wbIdx (wbDest)
  );

  assign exExtSign  = exOut.extSign;
  assign exAluImm   = exOut.aluImm;
  assign exAluFn    = exOut.aluFn;
  assign exPickRd   = exOut.pickRd;
  assign memWrite   = memOut.memWrite;
  assign memBranch  = memOut.isBranch;
  assign wbMemToReg = wbOut.memToReg;
  assign wbRegWrite = wbOut.regWrite;
endmodule

// File: rtl/ctrl_checker.sv
module ctrl_checker #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [5:0]       opcode,
  input logic             bubbleReq,
  input logic [2:0]       flushMask,
  input logic             exExtSign,
  input logic             exAluImm,
  input logic [2:0]       exAluFn,
  input logic             exPickRd,
  input logic             memWrite,
  input logic             memBranch,
  input logic             wbMemToReg,
  input logic             wbRegWrite,
  input logic [IDX_W-1:0] wbDest
);
  logic opKnown;
  assign opKnown = (opcode == 6'h00) || (opcode == 6'h23) ||
                   (opcode == 6'h2B) || (opcode == 6'h04);

  // R4
  store_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(opcode == 6'h2B && !bubbleReq && !flushMask[0], 2) &&
     !$past(flushMask[1]) && !$past(rst, 1) && !$past(rst, 2)) |-> memWrite);

  // R5
  branch_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (memBranch && !flushMask[2]) |=> !wbRegWrite);

  // R8
  bubble_empty_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(bubbleReq) && !$past(rst)) |->
      (!exExtSign && !exAluImm && exAluFn == 3'd0 && !exPickRd));

  // R7
  bad_op_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(opKnown) && !$past(rst)) |->
      (!exExtSign && !exAluImm && exAluFn == 3'd0 && !exPickRd));

  // R9
  wb_flush_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(flushMask[2]) && !$past(rst)) |->
      (!wbRegWrite && !wbMemToReg && wbDest == '0));

  // R2
  load_pair_chk: assert property (@(posedge clk) disable iff (rst)
    wbMemToReg |-> wbRegWrite);
endmodule

bind staged_ctrl_decoder ctrl_checker #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .opcode    (opcode),
  .bubbleReq (bubbleReq),
  .flushMask (flushMask),
  .exExtSign (exExtSign),
  .exAluImm  (exAluImm),
  .exAluFn   (exAluFn),
  .exPickRd  (exPickRd),
  .memWrite  (memWrite),
  .memBranch (memBranch),
  .wbMemToReg(wbMemToReg),
  .wbRegWrite(wbRegWrite),
  .wbDest    (wbDest)
);

// File: tb/sim_staged_ctrl_decoder.sv
`timescale 1ns/1ps
module sim_staged_ctrl_decoder;
  localparam int IDX_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic [IDX_W-1:0] srcRt = '0;
  logic [IDX_W-1:0] srcRd = '0;
  logic bubbleReq = 1'b0;
  logic [2:0] flushMask = '0;
  logic exExtSign, exAluImm, exPickRd, memWrite, memBranch, wbMemToReg, wbRegWrite;
  logic [2:0] exAluFn;
  logic [IDX_W-1:0] wbDest;

  always #2 clk = ~clk;

  staged_ctrl_decoder #(.IDX_W(IDX_W)) u0 (.*);

  typedef struct {
    int ext, imm, fn, pick, mw, br, m2r, rw, dest;
  } slot_t;

  slot_t pq[$];
  int total = 0;
  int bad = 0;
  bit started = 0;
  bit finished = 0;
  string curReq = "R1";

  function automatic slot_t emptySlot();
    slot_t s;
    s.ext = 0; s.imm = 0; s.fn = 0; s.pick = 0; s.mw = 0;
    s.br = 0; s.m2r = 0; s.rw = 0; s.dest = 0;
    return s;
  endfunction

  function automatic slot_t refDecode(int op, int fn, int rt, int rd);
    slot_t s = emptySlot();
    if (op == 'h00) begin
      if      (fn == 'h20) s.fn = 0;
      else if (fn == 'h22) s.fn = 1;
      else if (fn == 'h24) s.fn = 2;
      else if (fn == 'h25) s.fn = 3;
      else if (fn == 'h2A) s.fn = 4;
      else return emptySlot();
      s.pick = 1; s.rw = 1; s.dest = rd;
    end else if (op == 'h23) begin
      s.ext = 1; s.imm = 1; s.m2r = 1; s.rw = 1; s.dest = rt;
    end else if (op == 'h2B) begin
      s.ext = 1; s.imm = 1; s.mw = 1; s.dest = rt;
    end else if (op == 'h04) begin
      s.ext = 1; s.fn = 1; s.br = 1; s.dest = rt;
    end
    return s;
  endfunction

  initial begin
    for (int i = 0; i < 3; i++) pq.push_back(emptySlot());
  end

  // behavioural model: front of queue is EX, back is WB
  always @(posedge clk) begin
    slot_t nx, nm, nw;
    if (rst) begin
      nx = emptySlot(); nm = emptySlot(); nw = emptySlot();
    end else begin
      nx = (bubbleReq || flushMask[0]) ? emptySlot()
           : refDecode(int'(opcode), int'(funct), int'(srcRt), int'(srcRd));
      nm = flushMask[1] ? emptySlot() : pq[0];
      nw = flushMask[2] ? emptySlot() : pq[1];
    end
    pq.delete();
    pq.push_back(nx); pq.push_back(nm); pq.push_back(nw);
    started = 1;
  end

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      check(curReq, "ex", int'({exExtSign, exAluImm, exAluFn, exPickRd}),
            (pq[0].ext << 5) | (pq[0].imm << 4) | (pq[0].fn << 1) | pq[0].pick);
      check(curReq, "mem", int'({memWrite, memBranch}), (pq[1].mw << 1) | pq[1].br);
      check(curReq, "wb", int'({wbMemToReg, wbRegWrite}), (pq[2].m2r << 1) | pq[2].rw);
      check("R10", "dest", int'(wbDest), pq[2].dest);
    end
  end

  task automatic issue(int op, int fn, int rt, int rd, bit bub, int fl);
    @(negedge clk);
    #0.5;
    opcode = op[5:0]; funct = fn[5:0];
    srcRt = rt[IDX_W-1:0]; srcRd = rd[IDX_W-1:0];
    bubbleReq = bub; flushMask = fl[2:0];
  endtask

  task automatic drain();
    for (int i = 0; i < 4; i++) issue('h3F, 0, 0, 0, 0, 0);
  endtask

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    // R1: reset holds everything empty even with a load on the inputs
    curReq = "R1";
    issue('h23, 0, 7, 9, 0, 0);
    repeat (3) @(negedge clk);
    issue('h23, 0, 7, 9, 0, 0);
    rst = 1'b0;

    curReq = "R2";
    for (int i = 1; i < 5; i++) issue('h23, 'h11, i * 3, 31 - i, 0, 0);
    drain();

    curReq = "R3";
    issue('h00, 'h20, 1, 2, 0, 0);
    issue('h00, 'h22, 3, 4, 0, 0);
    issue('h00, 'h24, 5, 6, 0, 0);
    issue('h00, 'h25, 7, 8, 0, 0);
    issue('h00, 'h2A, 9, 10, 0, 0);
    drain();

    curReq = "R4";
    for (int i = 0; i < 3; i++) issue('h2B, 0, 12 + i, 20, 0, 0);
    drain();

    curReq = "R5";
    issue('h04, 0, 17, 18, 0, 0);
    issue('h23, 0, 19, 1, 0, 0);
    issue('h04, 0, 21, 22, 0, 0);
    drain();

    curReq = "R7";
    issue('h08, 'h20, 3, 4, 0, 0);
    issue('h00, 'h00, 5, 6, 0, 0);
    issue('h00, 'h27, 7, 8, 0, 0);
    issue('h3F, 'h20, 9, 10, 0, 0);
    drain();

    curReq = "R8";
    issue('h23, 0, 4, 0, 1, 0);
    issue('h00, 'h20, 1, 2, 1, 0);
    issue('h2B, 0, 6, 0, 0, 0);
    issue('h04, 0, 8, 0, 1, 0);
    drain();

    curReq = "R9";
    for (int f = 1; f < 8; f++) begin
      issue('h23, 0, f, 0, 0, 0);
      issue('h00, 'h25, 0, f + 8, 0, 0);
      issue('h2B, 0, f + 16, 0, 0, f);
      issue('h23, 0, 2, 0, 0, 0);
      issue('h00, 'h20, 0, 3, 0, f);
      drain();
    end

    curReq = "R6";
    for (int i = 0; i < 300; i++) begin
      int pick, op, fn;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pick = int'(lfsr[2:0]);
      case (pick)
        0, 1: op = 'h00;
        2: op = 'h23;
        3: op = 'h2B;
        4: op = 'h04;
        5: op = 'h23;
        default: op = int'(lfsr[8:3]);
      endcase
      case (lfsr[5:3])
        0: fn = 'h20; 1: fn = 'h22; 2: fn = 'h24; 3: fn = 'h25;
        4: fn = 'h2A; default: fn = int'(lfsr[11:6]);
      endcase
      issue(op, fn, int'(lfsr[12:8]), int'(lfsr[15:11]),
            (i > 150) && (lfsr[9:7] == 3'd0),
            (i > 200 && lfsr[10:8] == 3'd5) ? int'(lfsr[2:0]) : 0);
    end
    drain();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule